// File: doc/BRIEF.md
# PLL Mode and Bandwidth Sequencer

This block supervises one digital PLL channel. It keeps a registered 2-bit operating mode and moves it between four states. Moves are driven by a flag saying the selected input clock is usable, a lock-detect flag from the phase path, and a flag saying the holdover history is good enough to use. The four states are FREERUN, ACQUIRE, LOCKED and HOLDOVER. Each channel carries its own instance and configuration, and nothing is shared between instances.

The block also picks the loop-bandwidth code passed to the loop filter. During acquisition it can substitute a wider, separately programmed fastlock code, clamped into its legal window. It restores the normal code by itself once lock is reached. Mode codes are FREERUN=0, ACQUIRE=1, LOCKED=2, HOLDOVER=3.

The named transitions are:
- FREERUN→ACQUIRE: the input becomes valid.
- ACQUIRE→LOCKED: lock detect is debounced for a programmable dwell.
- ACQUIRE→FREERUN: the input is lost before lock.
- LOCKED→HOLDOVER: the input is lost and history is valid.
- LOCKED→FREERUN: the input is lost and history is not valid.
- HOLDOVER→ACQUIRE: the input returns.

Single-cycle strobes flag each mode change, each entry into LOCKED, and each input loss out of ACQUIRE or LOCKED. A level output shows when the output frequency is set by the external reference, which is in FREERUN and HOLDOVER.

Top module: `pll_mode_seq`

## Requirements
- R1: Reset (synchronous, active high) sets the mode to FREERUN (code 0), clears all three strobes, sets `on_ref_o` high, and leaves `bw_code_o` equal to `bw_norm_i`.
- R2: In FREERUN, a high `in_valid_i` at a clock edge makes the mode ACQUIRE from that edge.
- R3: In ACQUIRE with `in_valid_i` high, the move to LOCKED happens at the edge ending the N-th consecutive cycle of `lock_det_i` high, where N = `lock_dwell_i` and a dwell of 0 acts as 1. A low cycle restarts the count, and cycles spent outside ACQUIRE never count.
- R4: In ACQUIRE, a low `in_valid_i` makes the mode FREERUN at the next edge, even when lock detect is high.
- R5: In LOCKED, a low `in_valid_i` makes the mode HOLDOVER at the next edge if `hist_valid_i` is high, and FREERUN otherwise. With the input valid, LOCKED is held whatever lock detect does.
- R6: In HOLDOVER, a high `in_valid_i` makes the mode ACQUIRE at the next edge.
- R7: While the mode is ACQUIRE, `bw_code_o` carries the clamped fastlock code if `fast_en_i` is high, and `bw_norm_i` if it is low.
- R8: The fastlock code is clamped to the window [FAST_LO, FAST_HI] (16 to 22 by default). A code below the window gives FAST_LO and a code above it gives FAST_HI.
- R9: In every mode other than ACQUIRE, `bw_code_o` equals `bw_norm_i` over its full range, so the normal code returns on lock with no outside action.
- R10: `mode_chg_o` is high for exactly the first cycle of each new mode. `lock_stb_o` is high for the first cycle of LOCKED. `loss_stb_o` is high for the first cycle after an input loss leaves ACQUIRE or LOCKED.
- R11: `on_ref_o` is high exactly while the mode is FREERUN or HOLDOVER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Selected input clock is usable |
| lock_det_i | input | 1 | Raw lock indication from the phase path |
| hist_valid_i | input | 1 | Holdover history is usable |
| fast_en_i | input | 1 | Apply the fastlock bandwidth during acquisition |
| bw_norm_i | input | BW_W | Normal loop-bandwidth code |
| bw_fast_i | input | BW_W | Fastlock loop-bandwidth code before clamping |
| lock_dwell_i | input | DWELL_W | Consecutive lock-detect cycles required |
| mode_o | output | 2 | Registered mode code |
| bw_code_o | output | BW_W | Bandwidth code sent to the loop filter |
| mode_chg_o | output | 1 | One-cycle strobe on any mode change |
| lock_stb_o | output | 1 | One-cycle strobe on entry into LOCKED |
| loss_stb_o | output | 1 | One-cycle strobe on input loss out of ACQUIRE or LOCKED |
| on_ref_o | output | 1 | Output frequency follows the external reference |

## Verification
The bench builds the block with DWELL_W=4, so the largest dwell of 15 is reached in a short run and the longest debounce is checked cycle by cycle up to its final edge. BW_W=5 with the default 16 to 22 fastlock window leaves codes on both sides of the window (2 and 31), so both clamp directions can be driven. The normal code is also swept to the top of its range. Dwell values of 0 and 2 cover the degenerate single-cycle debounce and a restart after a dropped lock-detect cycle.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [1:0] {
        MODE_FREERUN  = 2'd0,
        MODE_ACQUIRE  = 2'd1,
        MODE_LOCKED   = 2'd2,
        MODE_HOLDOVER = 2'd3
    } pll_mode_e;

endpackage

// File: rtl/pll_lock_dwell.sv
module pll_lock_dwell #(
    parameter int DWELL_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm_i,
    input  logic               lock_det_i,
    input  logic [DWELL_W-1:0] dwell_i,
    output logic               lock_ok_o
);
    localparam logic [DWELL_W-1:0] CNT_MAX = {DWELL_W{1'b1}};

    logic [DWELL_W-1:0] run_cnt;
    logic [DWELL_W:0]   need;
    logic [DWELL_W:0]   run_now;

    always_comb begin
        need      = (dwell_i == '0) ? {{DWELL_W{1'b0}}, 1'b1} : {1'b0, dwell_i};
        run_now   = {1'b0, run_cnt} + {{DWELL_W{1'b0}}, 1'b1};
        lock_ok_o = arm_i && lock_det_i && (run_now >= need);
    end

    always_ff @(posedge clk) begin
        if (rst || !arm_i || !lock_det_i) begin
            run_cnt <= '0;
        end else if (run_cnt != CNT_MAX) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R3
    count_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (!lock_det_i) |=> (run_cnt == '0));

endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
    import pll_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid_i,
    input  logic      lock_ok_i,
    input  logic      hist_valid_i,
    output pll_mode_e mode_o,
    output logic      chg_stb_o,
    output logic      lock_stb_o,
    output logic      loss_stb_o,
    output logic      on_ref_o
);
    pll_mode_e mode_q;
    pll_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_FREERUN: begin
                if (in_valid_i) mode_d = MODE_ACQUIRE;
            end
            MODE_ACQUIRE: begin
                if (!in_valid_i)    mode_d = MODE_FREERUN;
                else if (lock_ok_i) mode_d = MODE_LOCKED;
            end
            MODE_LOCKED: begin
                if (!in_valid_i) mode_d = hist_valid_i ? MODE_HOLDOVER : MODE_FREERUN;
            end
            MODE_HOLDOVER: begin
                if (in_valid_i) mode_d = MODE_ACQUIRE;
            end
            default: mode_d = MODE_FREERUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_FREERUN;
        else     mode_q <= mode_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            chg_stb_o  <= 1'b0;
            lock_stb_o <= 1'b0;
            loss_stb_o <= 1'b0;
            on_ref_o   <= 1'b1;
        end else begin
            chg_stb_o  <= (mode_d != mode_q);
            lock_stb_o <= (mode_q == MODE_ACQUIRE) && (mode_d == MODE_LOCKED);
            loss_stb_o <= !in_valid_i &&
                          ((mode_q == MODE_ACQUIRE) || (mode_q == MODE_LOCKED));
            on_ref_o   <= (mode_d == MODE_FREERUN) || (mode_d == MODE_HOLDOVER);
        end
    end

    assign mode_o = mode_q;

    // R2
    free_to_acq_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FREERUN && in_valid_i) |=> (mode_q == MODE_ACQUIRE));

    // R4
    acq_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_ACQUIRE && !in_valid_i) |=> (mode_q == MODE_FREERUN));

    // R5
    no_history_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_LOCKED && !in_valid_i && !hist_valid_i) |=> (mode_q == MODE_FREERUN));

    // R6
    hold_return_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_HOLDOVER && in_valid_i) |=> (mode_q == MODE_ACQUIRE));

    // R10
    chg_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        chg_stb_o |-> (mode_q != $past(mode_q)));

    // R11
    on_ref_chk: assert property (@(posedge clk) disable iff (rst)
        on_ref_o |-> (mode_q == MODE_FREERUN || mode_q == MODE_HOLDOVER));

endmodule

// File: rtl/pll_bw_mux.sv
module pll_bw_mux
    import pll_seq_pkg::*;
#(
    parameter int              BW_W    = 5,
    parameter logic [BW_W-1:0] FAST_LO = 16,
    parameter logic [BW_W-1:0] FAST_HI = 22
) (
    input  logic            rst,
    input  pll_mode_e       mode_i,
    input  logic            fast_en_i,
    input  logic [BW_W-1:0] norm_i,
    input  logic [BW_W-1:0] fast_i,
    output logic [BW_W-1:0] bw_o
);
    logic [BW_W-1:0] fast_lo_cl;
    logic [BW_W-1:0] fast_cl;

    generate
        if (FAST_LO == '0) begin : g_no_low
            assign fast_lo_cl = fast_i;
        end else begin : g_low
            assign fast_lo_cl = (fast_i < FAST_LO) ? FAST_LO : fast_i;
        end
    endgenerate

    assign fast_cl = (fast_lo_cl > FAST_HI) ? FAST_HI : fast_lo_cl;

    always_comb begin
        if (mode_i == MODE_ACQUIRE && fast_en_i) bw_o = fast_cl;
        else                                     bw_o = norm_i;
    end

    // R8
    always_comb begin
        if (!rst && mode_i == MODE_ACQUIRE && fast_en_i) begin
            fast_window_chk: assert (bw_o >= FAST_LO && bw_o <= FAST_HI);
        end
    end

endmodule

// File: rtl/pll_mode_seq.sv
module pll_mode_seq
    import pll_seq_pkg::*;
#(
    parameter int              BW_W    = 5,
    parameter int              DWELL_W = 8,
    parameter logic [BW_W-1:0] FAST_LO = 16,
    parameter logic [BW_W-1:0] FAST_HI = 22
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid_i,
    input  logic               lock_det_i,
    input  logic               hist_valid_i,
    input  logic               fast_en_i,
    input  logic [BW_W-1:0]    bw_norm_i,
    input  logic [BW_W-1:0]    bw_fast_i,
    input  logic [DWELL_W-1:0] lock_dwell_i,
    output logic [1:0]         mode_o,
    output logic [BW_W-1:0]    bw_code_o,
    output logic               mode_chg_o,
    output logic               lock_stb_o,
    output logic               loss_stb_o,
    output logic               on_ref_o
);
    pll_mode_e mode_q;
    logic      lock_ok;
    logic      dwell_arm;

    assign dwell_arm = (mode_q == MODE_ACQUIRE) && in_valid_i;

    pll_lock_dwell #(.DWELL_W(DWELL_W)) u_dwell (
        .clk        (clk),
        .rst        (rst),
        .arm_i      (dwell_arm),
        .lock_det_i (lock_det_i),
        .dwell_i    (lock_dwell_i),
        .lock_ok_o  (lock_ok)
    );

    pll_mode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .in_valid_i   (in_valid_i),
        .lock_ok_i    (lock_ok),
        .hist_valid_i (hist_valid_i),
        .mode_o       (mode_q),
        .chg_stb_o    (mode_chg_o),
        .lock_stb_o   (lock_stb_o),
        .loss_stb_o   (loss_stb_o),
        .on_ref_o     (on_ref_o)
    );

    pll_bw_mux #(.BW_W(BW_W), .FAST_LO(FAST_LO), .FAST_HI(FAST_HI)) u_bw (
        .rst       (rst),
        .mode_i    (mode_q),
        .fast_en_i (fast_en_i),
        .norm_i    (bw_norm_i),
        .fast_i    (bw_fast_i),
        .bw_o      (bw_code_o)
    );

    assign mode_o = mode_q;

    // R3
    lock_dwell_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_LOCKED && $past(mode_q) == MODE_ACQUIRE) |-> $past(lock_det_i));

endmodule

// File: tb/pll_mode_seq_test.sv
module pll_mode_seq_test;

    localparam int BW_W    = 5;
    localparam int DWELL_W = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               lock_det = 1'b0;
    logic               hist_valid = 1'b1;
    logic               fast_en = 1'b1;
    logic [BW_W-1:0]    bw_norm = 5'd3;
    logic [BW_W-1:0]    bw_fast = 5'd20;
    logic [DWELL_W-1:0] dwell = 4'd2;
    logic [1:0]         mode;
    logic [BW_W-1:0]    bw_code;
    logic               chg, lstb, lossb, on_ref;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pll_mode_seq #(.BW_W(BW_W), .DWELL_W(DWELL_W)) uut (
        .clk(clk), .rst(rst), .in_valid_i(in_valid), .lock_det_i(lock_det),
        .hist_valid_i(hist_valid), .fast_en_i(fast_en), .bw_norm_i(bw_norm),
        .bw_fast_i(bw_fast), .lock_dwell_i(dwell), .mode_o(mode),
        .bw_code_o(bw_code), .mode_chg_o(chg), .lock_stb_o(lstb),
        .loss_stb_o(lossb), .on_ref_o(on_ref)
    );

    // bits: [5] valid [4] lock_det [3] hist [2:1] expected mode [0] expected change strobe
    localparam logic [5:0] VEC [0:14] = '{
        6'b001_00_0, 6'b101_01_1, 6'b111_01_0, 6'b101_01_0, 6'b111_01_0,
        6'b111_10_1, 6'b101_10_0, 6'b001_11_1, 6'b001_11_0, 6'b111_01_1,
        6'b011_00_1, 6'b110_01_1, 6'b110_01_0, 6'b110_10_1, 6'b000_00_1
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic l, input logic h);
        in_valid   = v;
        lock_det   = l;
        hist_valid = h;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 chg", chg, 0);
        chk("R1 lock strobe", lstb, 0);
        chk("R1 loss strobe", lossb, 0);
        chk("R1 bw", bw_code, 3);
        chk("R11 on_ref at reset", on_ref, 1);
        rst = 1'b0;

        // table walk: R2 R3 R4 R5 R6 R7 R9 R10
        for (int i = 0; i < 15; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][3]);
            chk("R2-R6 table mode", mode, int'(VEC[i][2:1]));
            chk("R10 table chg", chg, int'(VEC[i][0]));
            chk("R7/R9 table bw", bw_code, (VEC[i][2:1] == 2'd1) ? 20 : 3);
            chk("R11 table on_ref", on_ref,
                (VEC[i][2:1] == 2'd0 || VEC[i][2:1] == 2'd3) ? 1 : 0);
        end

        // R3 dwell of zero acts as one; R10 lock/loss strobes
        dwell = 4'd0;
        step(1, 0, 1);
        chk("R2 enter acquire", mode, 1);
        step(1, 1, 1);
        chk("R3 dwell0 lock", mode, 2);
        chk("R10 lock strobe", lstb, 1);
        step(1, 0, 1);
        chk("R5 hold while valid", mode, 2);
        chk("R10 lock strobe one cycle", lstb, 0);
        chk("R10 chg one cycle", chg, 0);
        step(0, 0, 1);
        chk("R5 to holdover", mode, 3);
        chk("R10 loss strobe", lossb, 1);
        chk("R11 on_ref holdover", on_ref, 1);
        step(0, 0, 1);
        chk("R10 loss strobe one cycle", lossb, 0);

        // R8 clamp, R7 fastlock disable
        dwell   = 4'd2;
        bw_fast = 5'd2;
        step(1, 0, 1);
        chk("R6 holdover to acquire", mode, 1);
        chk("R8 clamp low", bw_code, 16);
        chk("R11 on_ref acquire", on_ref, 0);
        bw_fast = 5'd31;
        #1;
        chk("R8 clamp high", bw_code, 22);
        fast_en = 1'b0;
        #1;
        chk("R7 fastlock disabled", bw_code, 3);
        fast_en = 1'b1;

        // R9 normal code passthrough, R10 loss out of acquire
        step(0, 0, 1);
        chk("R4 acquire loss", mode, 0);
        chk("R10 loss from acquire", lossb, 1);
        bw_norm = 5'd31;
        #1;
        chk("R9 normal full range", bw_code, 31);
        bw_norm = 5'd3;

        // R3 longest dwell
        dwell = 4'd15;
        step(1, 0, 1);
        for (int k = 0; k < 14; k++) begin
            step(1, 1, 1);
            chk("R3 dwell15 waiting", mode, 1);
        end
        step(1, 1, 1);
        chk("R3 dwell15 locked", mode, 2);
        chk("R9 normal restored on lock", bw_code, 3);

        // R1 reset from locked
        rst = 1'b1;
        step(1, 1, 1);
        chk("R1 reset from locked", mode, 0);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule